// File: doc/BRIEF.md
# Power-Supply Management Bus Target with Strapped Address Pair

This block is the bus-facing front end of a power-supply management controller on a two-wire SMBus/I2C bus. It answers on two linked 7-bit addresses. One is a controller address that holds a write-protect flag. The other is a 256-byte user memory whose address sits 0x08 below the controller address in 7-bit form. A 3-bit strap picks the address pair and the protocol flavour. The strap is captured once, on the first clock after reset, and is never read again.

The host writes one memory byte by sending the memory address with the write bit, then a data pointer, then the data byte. It reads a byte by loading the pointer the same way, issuing a repeated START, addressing the memory for read and clocking one byte back. If the host acknowledges the byte instead of ending with a NACK, the block keeps streaming bytes. A read at the alert-response address returns the live status byte. An open-drain alert output reports the shutdown and warning bits of that status.

SCL and SDA each pass through a two-flop synchroniser and a three-sample agreement filter before edge detection. SDA is only ever pulled low, through an enable output. A clock held low past a timeout, counted in system clocks, releases SDA and returns the state machine to idle. START and STOP are honoured at any bit position.

Top module: `smb_tgt_addrsel`

## Requirements
- R1: With strap bits [1:0] equal to n, the block acknowledges 7-bit controller address 0x58+n (0xB0+2n on the wire) and memory address 0x50+n, and NACKs the other pairs.
- R2: `proto_o` is 1 for strap codes 4, 5 and 6. It is 0 for codes 0 to 3 and for code 7, the open strap, which therefore gives the PMBus-style protocol at 0x5B/0x53.
- R3: The strap is captured on the first clock after reset. Later strap changes alter neither the answered addresses nor `proto_o` until the next reset.
- R4: A memory write (address+W, pointer, data, STOP) stores the byte. A later read (address+W, pointer, repeated START, address+R, one byte, NACK) returns it. SDA driven by the target only changes while SCL is low.
- R5: Write protection is set after reset, and a controller read returns it in bit 0. Writing command 0x10 followed by a data byte to the controller address loads data bit 0 into the protect flag. While the flag is 1, memory writes are acknowledged and leave the memory unchanged.
- R6: A read at 7-bit address 0x0C (0x19 on the wire) returns `stat_i`. A write to that address is NACKed. `alert_oe` is high exactly when status bit 0 (shutdown) or bit 1 (warning) is set.
- R7: An address byte that matches no active address is NACKed. The target then acknowledges nothing, including its own address, until the next START.
- R8: The memory pointer advances after each data byte and wraps from 0xFF to 0x00.
- R9: If SCL stays low for more than `TMO_CYCLES` system clocks, SDA is released and the target returns to idle. The next transaction is served normally.
- R10: A START seen in the middle of a byte restarts address reception. In the idle state SDA is never driven.
- R11: A pulse on SCL or SDA shorter than three system clocks is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Level of the SCL line |
| sda_i | input | 1 | Level of the SDA line |
| strap_i | input | 3 | Address/protocol strap, captured once after reset |
| stat_i | input | 8 | Status byte; bit 0 shutdown, bit 1 warning |
| sda_oe | output | 1 | When 1, SDA is pulled low |
| alert_oe | output | 1 | When 1, the alert line is pulled low |
| proto_o | output | 1 | 0 selects the PMBus-style protocol, 1 the register/word protocol |

## Verification
The hardest condition to reach is a timeout while the target itself holds SDA low. A short timeout would otherwise go unnoticed on a released line. The stimulus sets the memory pointer to a byte whose top bit is 0 and addresses the memory for read. It then parks SCL low right after the address acknowledge, so the target is driving the first data bit. It confirms the line is held, waits past the limit and confirms release. A one-byte read afterwards shows the block has recovered. The filter is probed with a two-clock SCL dropout in the middle of an address bit, where one extra edge would shift the address and turn the acknowledge into a NACK.

// File: rtl/smb_tgt_addrsel.sv
`timescale 1ns/1ps
module smb_tgt_addrsel #(
  parameter int         TMO_CYCLES = 5_000_000,
  parameter int         MEM_DEPTH  = 256,
  parameter logic [7:0] WP_CMD     = 8'h10,
  parameter int         SD_BIT     = 0,
  parameter int         WN_BIT     = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic [7:0] stat_i,
  output logic       sda_oe,
  output logic       alert_oe,
  output logic       proto_o
);
  localparam int AW = $clog2(MEM_DEPTH);
  localparam int TW = $clog2(TMO_CYCLES + 1);
  localparam logic [6:0] ARA7 = 7'h0C;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_WR, S_TX, S_IGN} st_t;
  typedef enum logic [1:0] {T_CTL, T_MEM, T_ARA} tg_t;

  logic [1:0] scl_s, sda_s;
  logic [2:0] scl_h, sda_h;
  logic       scl_f, sda_f, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1; sda_s <= '1; scl_h <= '1; sda_h <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_h <= {scl_h[1:0], scl_s[1]};
      sda_h <= {sda_h[1:0], sda_s[1]};
      if (&scl_h) scl_f <= 1'b1; else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h) sda_f <= 1'b1; else if (~|sda_h) sda_f <= 1'b0;
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  wire scl_rise = scl_f & ~scl_p;
  wire scl_fall = ~scl_f & scl_p;
  wire start_c  = scl_f & scl_p & sda_p & ~sda_f;
  wire stop_c   = scl_f & scl_p & ~sda_p & sda_f;

  logic [2:0] strap_q;
  logic       strap_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q  <= 3'b111;
      strap_ok <= 1'b0;
    end else if (!strap_ok) begin
      strap_q  <= strap_i;
      strap_ok <= 1'b1;
    end
  end

  wire [6:0] ctl7 = {5'b10110, strap_q[1:0]};
  wire [6:0] mem7 = {5'b10100, strap_q[1:0]};
  assign proto_o  = strap_q[2] & ~(&strap_q[1:0]);
  assign alert_oe = stat_i[SD_BIT] | stat_i[WN_BIT];

  logic [TW-1:0] tmo_cnt;
  wire tmo_hit = (tmo_cnt == TW'(TMO_CYCLES));
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tmo_cnt <= '0;
    else if (scl_f)    tmo_cnt <= '0;
    else if (!tmo_hit) tmo_cnt <= tmo_cnt + 1'b1;
  end

  st_t        st;
  tg_t        tg;
  logic       rw, ackph, more, wp;
  logic [3:0] bitcnt;
  logic [7:0] shreg, txreg, cmd;
  logic [AW-1:0] ptr;
  logic [7:0] mem [MEM_DEPTH];

  wire [6:0] a7      = shreg[7:1];
  wire       hit_ctl = (a7 == ctl7);
  wire       hit_mem = (a7 == mem7);
  wire       hit_ara = (a7 == ARA7) & shreg[0];
  wire       byte_in = scl_fall & ~ackph & (bitcnt == 4'd8);
  wire       mem_we  = byte_in & (st == S_WR) & (tg == T_MEM) & ~wp;
  wire [7:0] tx_src  = (tg == T_MEM) ? mem[ptr] :
                       (tg == T_CTL) ? {7'b0, wp} : stat_i;

  always_ff @(posedge clk)
    if (mem_we) mem[ptr] <= shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tg <= T_CTL; rw <= 1'b0; ackph <= 1'b0; more <= 1'b0;
      wp <= 1'b1; bitcnt <= '0; shreg <= '0; txreg <= '0; cmd <= '0;
      ptr <= '0; sda_oe <= 1'b0;
    end else if (tmo_hit) begin
      st <= S_IDLE; ackph <= 1'b0; sda_oe <= 1'b0;
    end else if (start_c) begin
      st <= S_ADDR; bitcnt <= '0; ackph <= 1'b0; sda_oe <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE; ackph <= 1'b0; sda_oe <= 1'b0;
    end else begin
      case (st)
        S_ADDR, S_CMD, S_WR: begin
          if (scl_rise && !ackph && bitcnt != 4'd8) begin
            shreg  <= {shreg[6:0], sda_f};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_in) begin
            ackph  <= 1'b1;
            sda_oe <= 1'b1;
            if (st == S_ADDR) begin
              if (hit_ctl)      begin tg <= T_CTL; rw <= shreg[0]; end
              else if (hit_mem) begin tg <= T_MEM; rw <= shreg[0]; end
              else if (hit_ara) begin tg <= T_ARA; rw <= 1'b1; end
              else begin st <= S_IGN; ackph <= 1'b0; sda_oe <= 1'b0; end
            end else if (st == S_CMD) begin
              if (tg == T_MEM) ptr <= shreg[AW-1:0];
              else             cmd <= shreg;
            end else begin
              if (tg == T_MEM)        ptr <= ptr + 1'b1;
              else if (cmd == WP_CMD) wp  <= shreg[0];
            end
          end else if (scl_fall && ackph) begin
            ackph  <= 1'b0;
            bitcnt <= '0;
            if (st == S_ADDR && rw) begin
              st     <= S_TX;
              txreg  <= tx_src;
              sda_oe <= ~tx_src[7];
            end else begin
              sda_oe <= 1'b0;
              st     <= (st == S_ADDR) ? S_CMD : S_WR;
            end
          end
        end
        S_TX: begin
          if (scl_fall && !ackph) begin
            if (bitcnt == 4'd7) begin
              ackph  <= 1'b1;
              sda_oe <= 1'b0;
              if (tg == T_MEM) ptr <= ptr + 1'b1;
            end else begin
              bitcnt <= bitcnt + 1'b1;
              txreg  <= {txreg[6:0], 1'b0};
              sda_oe <= ~txreg[6];
            end
          end else if (scl_rise && ackph) begin
            more <= ~sda_f;
          end else if (scl_fall && ackph) begin
            ackph <= 1'b0;
            if (more) begin
              bitcnt <= '0;
              txreg  <= tx_src;
              sda_oe <= ~tx_src[7];
            end else begin
              st <= S_IGN;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/smb_tgt_addrsel_chk.sv
`timescale 1ns/1ps
module smb_tgt_addrsel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       scl_f,
  input logic [2:0] st,
  input logic       tmo_hit,
  input logic       wp,
  input logic       strap_ok,
  input logic [2:0] strap_q
);
  localparam logic [2:0] ST_IDLE = 3'd0;
  localparam logic [2:0] ST_IGN  = 3'd5;

  AST_SDA_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f)) |-> $stable(sda_oe)); // R4
  AST_TMO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_hit |=> !sda_oe); // R9
  AST_WP_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_ok |-> wp); // R5
  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    strap_ok |=> $stable(strap_q)); // R3
  AST_IGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IGN) |-> !sda_oe); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe); // R10
endmodule

bind smb_tgt_addrsel smb_tgt_addrsel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_f(scl_f), .st(st),
  .tmo_hit(tmo_hit), .wp(wp), .strap_ok(strap_ok), .strap_q(strap_q)
);

// File: tb/sim_smb_tgt_addrsel.sv
`timescale 1ns/1ps
module sim_smb_tgt_addrsel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'd7;
  logic [7:0] stat = 8'h00;
  logic sda_oe, alert_oe, proto_o;
  wire  sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  smb_tgt_addrsel #(.TMO_CYCLES(400)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(strap), .stat_i(stat), .sda_oe(sda_oe),
    .alert_oe(alert_oe), .proto_o(proto_o)
  );

  int    checks = 0, errors = 0;
  int    exp_q[$], obs_q[$];
  string tag_q[$];
  event  obs_ev;
  bit    done = 1'b0;

  task automatic expect_v(string tag, int e);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic observe(int o);
    obs_q.push_back(o);
    -> obs_ev;
  endtask

  function automatic void drain();
    while (obs_q.size() > 0 && exp_q.size() > 0) begin
      int o = obs_q.pop_front();
      int e = exp_q.pop_front();
      string t = tag_q.pop_front();
      checks++;
      if (o != e) begin
        errors++;
        $display("FAIL %s actual=%0h expected=%0h", t, o, e);
      end
    end
  endfunction

  initial forever begin
    @(obs_ev);
    drain();
  end

  task automatic chk(string tag, int act, int e);
    expect_v(tag, e);
    observe(act);
  endtask

  task automatic bus_start();
    sda_m = 1; #100; scl_m = 1; #100; sda_m = 0; #100; scl_m = 0; #100;
  endtask

  task automatic bus_stop();
    sda_m = 0; #100; scl_m = 1; #100; sda_m = 1; #100;
  endtask

  task automatic send(logic [7:0] b, int exp_ack, string tag, bit glitch = 0);
    expect_v(tag, exp_ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; #100; scl_m = 1; #100;
      if (glitch && i == 3) begin scl_m = 0; #10; scl_m = 1; #90; end
      else #100;
      scl_m = 0; #100;
    end
    sda_m = 1; #100; scl_m = 1; #100;
    observe(sda_line ? 0 : 1);
    #100; scl_m = 0; #100;
  endtask

  task automatic recv(int exp_b, bit mack, string tag);
    logic [7:0] b;
    expect_v(tag, exp_b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      #100; scl_m = 1; #100; b[i] = sda_line; #100; scl_m = 0;
    end
    #100; sda_m = mack ? 1'b0 : 1'b1; #100; scl_m = 1; #200; scl_m = 0; #100;
    sda_m = 1;
    observe(int'(b));
  endtask

  task automatic bits(logic [7:0] b, int n);
    for (int i = 0; i < n; i++) begin
      sda_m = b[7-i]; #100; scl_m = 1; #200; scl_m = 0; #100;
    end
  endtask

  task automatic do_reset(logic [2:0] s);
    rst_n = 0; strap = s; scl_m = 1; sda_m = 1;
    repeat (5) @(posedge clk);
    #1; rst_n = 1; #100;
  endtask

  task automatic ctl_write(logic [7:0] c, logic [7:0] d, string tag);
    bus_start(); send(8'hB6, 1, tag); send(c, 1, tag); send(d, 1, tag); bus_stop();
  endtask

  task automatic ctl_read(int e, string tag);
    bus_start(); send(8'hB7, 1, tag); recv(e, 0, tag); bus_stop();
  endtask

  task automatic mem_write(logic [7:0] p, logic [7:0] d, string tag);
    bus_start(); send(8'hA6, 1, tag); send(p, 1, tag); send(d, 1, tag); bus_stop();
  endtask

  task automatic mem_read(logic [7:0] p, int e, string tag);
    bus_start(); send(8'hA6, 1, tag); send(p, 1, tag);
    bus_start(); send(8'hA7, 1, tag); recv(e, 0, tag); bus_stop();
  endtask

  task automatic summary();
    drain();
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard actual=%0d expected=0 pending items", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #900000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // strap 2: controller 0x5A (0xB4), memory 0x52 (0xA4)
    do_reset(3'd2);
    chk("R2 code 2 PMBus-style", proto_o, 0);
    chk("R10 reset SDA released", sda_oe, 0);
    bus_start(); send(8'hB5, 1, "R1 ctl addr code 2"); recv(1, 0, "R5 protect set after reset"); bus_stop();
    bus_start(); send(8'hA4, 1, "R1 mem addr code 2"); bus_stop();
    bus_start(); send(8'hB6, 0, "R1 other pair NACK"); bus_stop();
    strap = 3'd5; #1000;
    chk("R3 proto unchanged after strap move", proto_o, 0);
    bus_start(); send(8'hB4, 1, "R3 latched addr still acked"); bus_stop();
    bus_start(); send(8'hB2, 0, "R3 new strap addr ignored"); bus_stop();

    do_reset(3'd5);
    chk("R2 code 5 register/word", proto_o, 1);
    bus_start(); send(8'hB2, 1, "R1 ctl addr code 5"); bus_stop();
    bus_start(); send(8'hA2, 1, "R1 mem addr code 5"); bus_stop();

    do_reset(3'd3);
    chk("R2 code 3 PMBus-style", proto_o, 0);

    do_reset(3'd7);
    chk("R2 open strap PMBus-style", proto_o, 0);
    chk("R6 alert idle", alert_oe, 0);

    ctl_write(8'h10, 8'h00, "R5 clear protect");
    ctl_read(0, "R5 protect cleared");
    mem_write(8'h10, 8'h3C, "R4 write");
    ctl_write(8'h10, 8'h01, "R5 set protect");
    mem_write(8'h10, 8'hA5, "R5 protected write acked");
    mem_read(8'h10, 8'h3C, "R5 protected write ignored");
    ctl_write(8'h10, 8'h00, "R5 clear protect again");
    mem_write(8'h10, 8'hA5, "R4 write");
    mem_read(8'h10, 8'hA5, "R4 read back");
    mem_write(8'h44, 8'h5E, "R4 write");
    mem_read(8'h44, 8'h5E, "R4 read back 2");
    mem_read(8'h10, 8'hA5, "R4 first byte kept");

    mem_write(8'hFF, 8'h11, "R8 write top");
    mem_write(8'h00, 8'h22, "R8 write bottom");
    bus_start(); send(8'hA6, 1, "R8"); send(8'hFF, 1, "R8");
    bus_start(); send(8'hA7, 1, "R8");
    recv(8'h11, 1, "R8 byte at 0xFF"); recv(8'h22, 0, "R8 wrap to 0x00"); bus_stop();

    stat = 8'h42; #100;
    chk("R6 alert on warning", alert_oe, 1);
    bus_start(); send(8'h19, 1, "R6 alert-response ack"); recv(8'h42, 0, "R6 status byte"); bus_stop();
    stat = 8'h80; #100;
    chk("R6 alert off for other bits", alert_oe, 0);
    stat = 8'h01; #100;
    chk("R6 alert on shutdown", alert_oe, 1);
    bus_start(); send(8'h19, 1, "R6 alert-response ack"); recv(8'h01, 0, "R6 status byte 2"); bus_stop();
    bus_start(); send(8'h18, 0, "R6 write at alert address NACK"); bus_stop();
    stat = 8'h00;

    bus_start(); send(8'hC0, 0, "R7 unknown address NACK");
    send(8'h00, 0, "R7 ignored byte");
    send(8'hA6, 0, "R7 own address ignored until START"); bus_stop();

    bus_start(); send(8'hA6, 1, "R11 ack with SCL glitch", 1); send(8'h44, 1, "R11");
    bus_start(); send(8'hA7, 1, "R11"); recv(8'h5E, 0, "R11 read after glitch"); bus_stop();

    bus_start(); bits(8'hFF, 5);
    bus_start(); send(8'hB7, 1, "R10 START mid-byte resync"); recv(0, 0, "R10 read after resync"); bus_stop();

    mem_write(8'h20, 8'h0F, "R9 setup");
    bus_start(); send(8'hA6, 1, "R9"); send(8'h20, 1, "R9");
    bus_start(); send(8'hA7, 1, "R9");
    #500;
    chk("R9 target driving before timeout", sda_oe, 1);
    #2000;
    chk("R9 SDA released after timeout", sda_oe, 0);
    bus_stop();
    mem_read(8'h20, 8'h0F, "R9 recovery read");

    done = 1'b1;
    #1000;
    summary();
    $finish;
  end
endmodule